// File: doc/BRIEF.md
# Dual-Algorithm Bus Arbiter

This block decides which of seven bus masters owns a shared parallel bus. One master is the local host agent, which talks to the arbiter through active-high request and grant signals. The other six are external agents on pins with active-low request and grant lines. Ownership is granted in one of two ways:

- **Fixed priority:** the host always comes first, then external agent 0 upward.
- **Rotating order:** the host, then external agents 0 to 5, then back to the host.

A strap input sampled during reset picks the starting algorithm. A one-cycle control write can change it later.

After reset, and every time the arbiter is re-enabled, no grant is issued for a blackout window of eight cycles. A grant only moves when the bus is idle or the current owner has let go of its request, and a cycle with no grant always separates two owners. In external-arbiter mode the block stops arbitrating. Instead it drives the host's request onto request pin 0, takes the host's grant from grant pin 0, and holds every unused pin high.

Top module: `dual_mode_bus_arbiter`

## Requirements
- R1: While reset is low and in the first cycle after it, every active-low grant pin is 1 and `host_gnt` is 0.
- R2: After reset is released with `arb_en` high, no grant appears in the first eight cycles. The first grant appears on the ninth rising edge. The same holds after `arb_en` returns high.
- R3: In fixed-priority mode the winner is the lowest-numbered requester in the order host, ext0, ext1, ext2, ext3, ext4, ext5. An owner that keeps requesting is not displaced by a lower-priority requester.
- R4: In rotating mode the search starts at the agent after the last owner, in the circular order host, ext0 … ext5, host. Agents without a request are skipped.
- R5: `boot_rotate` is captured while reset is low: 1 selects rotating order and 0 selects fixed priority.
- R6: A cycle with `ctl_wr`=1 sets the algorithm from `ctl_rotate` (1 = rotating), which overrides the strap.
- R7: At most one grant (`host_gnt` or a low `gnt_n_o` bit) is active at any time. Between two different owners there is at least one cycle with no grant.
- R8: While an owner holds its request and `bus_idle` is 0, the grant does not move. With `bus_idle`=1, or once the owner drops its request, the grant is removed for one cycle and then given to the new winner.
- R9: With `ext_arb`=1, the pins behave as follows:
  - `gnt_n_o` is all ones.
  - `gnt_n_oe` is 6'b111110.
  - `req_n_oe` is all ones, except bit 0, which is 0 while reset is low.
  - `req_n_o[5:1]` is all ones.
  - `req_n_o[0]` equals the inverse of `host_req`.
  - `req_n_i` causes no grant.
- R10: With `ext_arb`=1, `host_gnt` shows the inverse of `gnt0_n_i` one cycle later. It stays 0 while reset is low, whatever level `gnt0_n_i` has.
- R11: One cycle after `arb_en` goes low, no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (bus reset) |
| arb_en | input | 1 | Arbiter enable; a rise restarts the blackout window |
| ext_arb | input | 1 | 1 = external-arbiter mode (bypass) |
| boot_rotate | input | 1 | Strap: default algorithm, captured in reset |
| ctl_wr | input | 1 | Control write strobe for the algorithm bit |
| ctl_rotate | input | 1 | Algorithm value written when `ctl_wr` is 1 |
| bus_idle | input | 1 | Bus is idle; allows the grant to move |
| host_req | input | 1 | Host agent request, active high |
| host_gnt | output | 1 | Host agent grant, active high |
| req_n_i | input | 6 | External requests, active low |
| req_n_o | output | 6 | Request pin drive values (used in external-arbiter mode) |
| req_n_oe | output | 6 | Request pin output enables |
| gnt_n_o | output | 6 | External grants, active low |
| gnt_n_oe | output | 6 | Grant pin output enables |
| gnt0_n_i | input | 1 | Grant pin 0 input from an external arbiter |

## Verification
Two events can fall on the same clock edge:

- **End of the blackout with waiting requests.** Requests are already present when the blackout counter saturates. The bench holds all seven requests through the window and checks that nothing is granted for eight cycles and that the host is granted exactly on the ninth edge.
- **Enable drop against a live owner.** `arb_en` is removed while an owner holds the bus. The bench expects the grant gone one cycle later and the full eight-cycle window again after re-enable.

The rotation walk with every agent requesting and the bus idle forces a release and a regrant on every other edge. The bench judges that walk by the exact owner order and by the empty cycle between owners.

// File: rtl/arb_pkg.sv
// Package: shared sizes and types for the dual-algorithm bus arbiter.
// Assumes agent 0 is the host and agents 1..NUM_EXT are the external pins.
package arb_pkg;
    localparam int NUM_EXT     = 6;
    localparam int NUM_AGENTS  = NUM_EXT + 1;
    localparam int IDX_W       = $clog2(NUM_AGENTS);
    localparam int HOLD_CYCLES = 8;

    typedef enum logic {
        ALG_FIXED  = 1'b0,
        ALG_ROTATE = 1'b1
    } arb_alg_e;
endpackage

// File: rtl/arb_holdoff.sv
// Module: blackout counter. Counts enabled cycles after reset and saturates
// at HOLD; ready is high only once saturated. Assumes run low restarts it.
module arb_holdoff #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ready
);
    localparam int CNT_W = $clog2(HOLD + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count enabled cycles up to HOLD, clearing on reset or when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_W'(HOLD)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The window is over once the count has saturated.
    always_comb ready = (cnt_q == CNT_W'(HOLD));
endmodule

// File: rtl/arb_pick.sv
// Module: winner selection. Computes both the fixed-priority winner (lowest
// index) and the rotating winner (first requester after last). rotate picks
// one. Purely combinational; assumes last < N.
module arb_pick #(
    parameter int N = 7
) (
    input  logic [N-1:0]         req,
    input  logic [$clog2(N)-1:0] last,
    input  logic                 rotate,
    output logic                 found,
    output logic [$clog2(N)-1:0] win
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] fx_idx;
    logic [IW-1:0] rr_idx;

    // Fixed priority: scan from the top so the lowest requester wins.
    always_comb begin
        fx_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) fx_idx = IW'(i);
        end
    end

    // Rotation: scan offsets downward so the nearest one after last wins.
    always_comb begin
        rr_idx = '0;
        for (int k = N; k >= 1; k--) begin
            int j;
            j = (int'(last) + k) % N;
            if (req[j]) rr_idx = IW'(j);
        end
    end

    // Choose the variant and report whether anyone requests.
    always_comb begin
        found = |req;
        win   = rotate ? rr_idx : fx_idx;
    end
endmodule

// File: rtl/arb_pins.sv
// Module: pin mapping. In internal mode it drives the active-low grants and
// leaves the request pins as inputs. In external-arbiter mode it drives the
// host request out, floats it in reset, and holds unused pins high.
module arb_pins #(
    parameter int NUM_EXT = 6
) (
    input  logic               rst_n,
    input  logic               ext_mode,
    input  logic               host_req,
    input  logic               host_grant_int,
    input  logic               host_grant_ext,
    input  logic [NUM_EXT-1:0] ext_grant,
    output logic               host_gnt,
    output logic [NUM_EXT-1:0] req_n_o,
    output logic [NUM_EXT-1:0] req_n_oe,
    output logic [NUM_EXT-1:0] gnt_n_o,
    output logic [NUM_EXT-1:0] gnt_n_oe
);
    localparam logic [NUM_EXT-1:0] ALL1 = '1;

    // Select pin levels and enables for the active mode.
    always_comb begin
        if (ext_mode) begin
            host_gnt = host_grant_ext;
            gnt_n_o  = ALL1;
            gnt_n_oe = {ALL1[NUM_EXT-1:1], 1'b0};
            req_n_o  = {ALL1[NUM_EXT-1:1], ~host_req};
            req_n_oe = {ALL1[NUM_EXT-1:1], rst_n};
        end else begin
            host_gnt = host_grant_int;
            gnt_n_o  = ~ext_grant;
            gnt_n_oe = ALL1;
            req_n_o  = ALL1;
            req_n_oe = '0;
        end
    end
endmodule

// File: rtl/dual_mode_bus_arbiter.sv
// Module: top of the arbiter. Holds the one-hot grant state, the last owner,
// and the algorithm bit. Assumes the pins are already synchronous to clk.
// Agent 0 is the host and agent i+1 is external pin i.
module dual_mode_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_EXT_P = arb_pkg::NUM_EXT,
    parameter int HOLD_P    = arb_pkg::HOLD_CYCLES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arb_en,
    input  logic                 ext_arb,
    input  logic                 boot_rotate,
    input  logic                 ctl_wr,
    input  logic                 ctl_rotate,
    input  logic                 bus_idle,
    input  logic                 host_req,
    output logic                 host_gnt,
    input  logic [NUM_EXT_P-1:0] req_n_i,
    output logic [NUM_EXT_P-1:0] req_n_o,
    output logic [NUM_EXT_P-1:0] req_n_oe,
    output logic [NUM_EXT_P-1:0] gnt_n_o,
    output logic [NUM_EXT_P-1:0] gnt_n_oe,
    input  logic                 gnt0_n_i
);
    localparam int N  = NUM_EXT_P + 1;
    localparam int IW = $clog2(N);

    arb_alg_e      alg_q;
    logic [N-1:0]  grant_q;
    logic [IW-1:0] last_q;
    logic          ext_gnt_q;
    logic          run;
    logic          ready;
    logic [N-1:0]  req_vec;
    logic          found;
    logic [IW-1:0] win;
    logic [N-1:0]  win_oh;
    logic          has_owner;
    logic          may_decide;

    // Strap value in reset; a control write overrides it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alg_q <= boot_rotate ? ALG_ROTATE : ALG_FIXED;
        end else if (ctl_wr) begin
            alg_q <= ctl_rotate ? ALG_ROTATE : ALG_FIXED;
        end
    end

    // Gather requests and decide whether the grant may move this cycle.
    always_comb begin
        run        = arb_en & ~ext_arb;
        req_vec    = {~req_n_i, host_req};
        has_owner  = |grant_q;
        may_decide = !has_owner || bus_idle || !(|(grant_q & req_vec));
        win_oh     = found ? (N'(1) << win) : '0;
    end

    arb_holdoff #(.HOLD(HOLD_P)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ready (ready)
    );

    arb_pick #(.N(N)) u_pick (
        .req    (req_vec),
        .last   (last_q),
        .rotate (alg_q == ALG_ROTATE),
        .found  (found),
        .win    (win)
    );

    // Grant state: release before any change of owner, grant from empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            last_q  <= IW'(N - 1);
        end else if (!(ready && run)) begin
            grant_q <= '0;
        end else if (may_decide) begin
            if (has_owner) begin
                if (win_oh != grant_q) grant_q <= '0;
            end else if (found) begin
                grant_q <= win_oh;
                last_q  <= win;
            end
        end
    end

    // Register the external grant for the host, ignoring it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_gnt_q <= 1'b0;
        else        ext_gnt_q <= ext_arb & ~gnt0_n_i;
    end

    arb_pins #(.NUM_EXT(NUM_EXT_P)) u_pins (
        .rst_n          (rst_n),
        .ext_mode       (ext_arb),
        .host_req       (host_req),
        .host_grant_int (grant_q[0]),
        .host_grant_ext (ext_gnt_q),
        .ext_grant      (grant_q[N-1:1]),
        .host_gnt       (host_gnt),
        .req_n_o        (req_n_o),
        .req_n_oe       (req_n_oe),
        .gnt_n_o        (gnt_n_o),
        .gnt_n_oe       (gnt_n_oe)
    );
endmodule

// File: rtl/arb_checker.sv
// Module: property checker bound to the arbiter top. It watches ports only
// and keeps its own count of the blackout window.
module arb_checker #(
    parameter int NUM_EXT = 6,
    parameter int HOLD    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               arb_en,
    input logic               ext_arb,
    input logic               host_req,
    input logic               host_gnt,
    input logic               gnt0_n_i,
    input logic [NUM_EXT-1:0] req_n_o,
    input logic [NUM_EXT-1:0] req_n_oe,
    input logic [NUM_EXT-1:0] gnt_n_o,
    input logic [NUM_EXT-1:0] gnt_n_oe
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [NUM_EXT-1:0] ONES = '1;

    logic [NUM_EXT:0] g;
    logic [HW-1:0]    hc_q;

    // Grant vector seen on the pins in internal mode.
    always_comb g = ext_arb ? '0 : {~gnt_n_o, host_gnt};

    // Independent count of enabled cycles since reset or re-enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !arb_en || ext_arb) hc_q <= '0;
        else if (hc_q != HW'(HOLD))       hc_q <= hc_q + 1'b1;
    end

    a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(g));

    a_r7_gap_between_owners: assert property (@(posedge clk) disable iff (!rst_n)
        (g != '0) |=> (g == '0) || (g == $past(g)));

    a_r2_no_grant_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (g != '0) |-> (hc_q == HW'(HOLD)));

    a_r9_bypass_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ext_arb |-> (gnt_n_o == ONES) && (gnt_n_oe == {ONES[NUM_EXT-1:1], 1'b0})
                    && (req_n_o == {ONES[NUM_EXT-1:1], ~host_req})
                    && (req_n_oe == ONES));

    a_r10_host_grant_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_arb && $past(ext_arb) && $past(rst_n)) |-> (host_gnt == !$past(gnt0_n_i)));

    a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> (g == '0));
endmodule

bind dual_mode_bus_arbiter arb_checker #(.NUM_EXT(NUM_EXT_P), .HOLD(HOLD_P)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arb_en   (arb_en),
    .ext_arb  (ext_arb),
    .host_req (host_req),
    .host_gnt (host_gnt),
    .gnt0_n_i (gnt0_n_i),
    .req_n_o  (req_n_o),
    .req_n_oe (req_n_oe),
    .gnt_n_o  (gnt_n_o),
    .gnt_n_oe (gnt_n_oe)
);

// File: tb/dual_mode_bus_arbiter_test.sv
module dual_mode_bus_arbiter_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, arb_en, ext_arb, boot_rotate, ctl_wr, ctl_rotate;
    logic       bus_idle, host_req, host_gnt, gnt0_n_i;
    logic [5:0] req_n_i, req_n_o, req_n_oe, gnt_n_o, gnt_n_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_mode_bus_arbiter uut (
        .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .ext_arb(ext_arb),
        .boot_rotate(boot_rotate), .ctl_wr(ctl_wr), .ctl_rotate(ctl_rotate),
        .bus_idle(bus_idle), .host_req(host_req), .host_gnt(host_gnt),
        .req_n_i(req_n_i), .req_n_o(req_n_o), .req_n_oe(req_n_oe),
        .gnt_n_o(gnt_n_o), .gnt_n_oe(gnt_n_oe), .gnt0_n_i(gnt0_n_i)
    );

    // -1 none, 0 host, i+1 external agent i
    function automatic int owner();
        if (host_gnt) return 0;
        for (int i = 0; i < 6; i++) if (!gnt_n_o[i]) return i + 1;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input bit boot);
        rst_n = 1'b0; arb_en = 1'b1; ext_arb = 1'b0; boot_rotate = boot;
        ctl_wr = 1'b0; ctl_rotate = 1'b0; bus_idle = 1'b1; host_req = 1'b0;
        req_n_i = 6'h3F; gnt0_n_i = 1'b1;
        step(); step();
        rst_n = 1'b1;
    endtask

    // Eight empty cycles, then the first owner on the ninth edge.
    task automatic window_then_grant(output int first);
        for (int c = 1; c <= 8; c++) begin
            step();
            chk(owner() == -1, "R2 window", owner(), -1);
        end
        step();
        first = owner();
        chk(first != -1, "R2 first grant", first, 0);
    endtask

    task automatic t_reset_and_window();
        int o;
        do_reset(1'b0);
        chk(gnt_n_o == 6'h3F && !host_gnt, "R1 grants idle", int'(gnt_n_o), 63);
        host_req = 1'b1; req_n_i = 6'h00;
        window_then_grant(o);
        chk(o == 0, "R2 host first", o, 0);
        arb_en = 1'b0;
        step();
        chk(owner() == -1, "R11 disable", owner(), -1);
        arb_en = 1'b1;
        window_then_grant(o);
        chk(o == 0, "R2 after re-enable", o, 0);
    endtask

    task automatic t_fixed();
        int o;
        do_reset(1'b0);
        host_req = 1'b1; req_n_i = 6'h00;
        window_then_grant(o);
        step();
        chk(owner() == 0, "R3 owner kept", owner(), 0);
        host_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step();
            chk(owner() == -1, "R7 gap", owner(), -1);
            step();
            chk(owner() == i + 1, "R3 priority order", owner(), i + 1);
            req_n_i[i] = 1'b1;
        end
    endtask

    task automatic t_rotate();
        int o;
        do_reset(1'b1);
        host_req = 1'b1; req_n_i = 6'h00;
        window_then_grant(o);
        chk(o == 0, "R5 rotate start", o, 0);
        for (int i = 1; i <= 7; i++) begin
            step();
            chk(owner() == -1, "R7 gap", owner(), -1);
            step();
            chk(owner() == (i % 7), "R4 rotation", owner(), i % 7);
        end
    endtask

    task automatic t_skip();
        int o;
        do_reset(1'b1);
        req_n_i = 6'b101101;
        window_then_grant(o);
        chk(o == 2, "R4 skip to ext1", o, 2);
        step(); step();
        chk(owner() == 5, "R4 skip to ext4", owner(), 5);
        step(); step();
        chk(owner() == 2, "R4 wrap to ext1", owner(), 2);
    endtask

    task automatic t_override();
        int o;
        do_reset(1'b1);
        ctl_wr = 1'b1; ctl_rotate = 1'b0;
        step();
        ctl_wr = 1'b0;
        host_req = 1'b1; req_n_i = 6'h00;
        for (int c = 1; c <= 7; c++) step();
        step();
        o = owner();
        chk(o == 0, "R6 fixed after write", o, 0);
        for (int c = 0; c < 4; c++) begin
            step();
            chk(owner() == 0, "R6 host kept", owner(), 0);
        end
    endtask

    task automatic t_idle();
        int o;
        do_reset(1'b0);
        bus_idle = 1'b0; req_n_i = 6'b111011;
        window_then_grant(o);
        chk(o == 3, "R8 first owner", o, 3);
        host_req = 1'b1;
        for (int c = 0; c < 4; c++) begin
            step();
            chk(owner() == 3, "R8 hold while busy", owner(), 3);
        end
        bus_idle = 1'b1;
        step();
        chk(owner() == -1, "R8 release", owner(), -1);
        step();
        chk(owner() == 0, "R8 regrant", owner(), 0);
    endtask

    task automatic t_external();
        do_reset(1'b0);
        ext_arb = 1'b1; req_n_i = 6'h00; host_req = 1'b1;
        step();
        chk(gnt_n_o == 6'h3F, "R9 grants high", int'(gnt_n_o), 63);
        chk(gnt_n_oe == 6'b111110, "R9 grant enables", int'(gnt_n_oe), 62);
        chk(req_n_o == 6'b111110, "R9 request drive", int'(req_n_o), 62);
        chk(req_n_oe == 6'h3F, "R9 request enables", int'(req_n_oe), 63);
        chk(!host_gnt, "R10 no grant yet", int'(host_gnt), 0);
        gnt0_n_i = 1'b0;
        step();
        chk(host_gnt, "R10 grant taken", int'(host_gnt), 1);
        rst_n = 1'b0;
        #1;
        chk(req_n_oe[0] == 1'b0, "R9 float in reset", int'(req_n_oe[0]), 0);
        step();
        chk(!host_gnt, "R10 ignored in reset", int'(host_gnt), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        t_reset_and_window();
        t_fixed();
        t_rotate();
        t_skip();
        t_override();
        t_idle();
        t_external();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule